// File: doc/BRIEF.md
# Byte-Serial AES-128 Round Sequencer

This block is the control sequencer for an encrypt-only AES-128 engine whose datapath handles one byte per clock. The host clocks a 16-byte state and a 16-byte key in together, one byte pair per cycle, then pulses a start strobe. The sequencer runs ten rounds of sixteen byte-steps each and holds a busy flag for that whole time. Once busy falls, the host raises an unload strobe and reads the result bytes, one per cycle. The next block may be loaded during that same unload.

The block drives the datapath stages but contains none of them. Its outputs are a byte-position counter, which also serves as the key-schedule step index. It also exports a round index and the matching round constant, a column-start strobe and a result-take pulse for the column mixer, and a key-schedule step code. Shift and load enables tell the state and key shift registers when to move.

The block has no data stream of its own, so every pin is a plain level or strobe. The host applies back-pressure to the unload side by dropping its unload strobe. The registers then stall and the position counter holds until the strobe returns.

Top module: `aes_bs_ctrl`

## Requirements
- R1: While reset (synchronous, active high) is held, and on the first cycle after it, busy, both counters, both enables and the column-start strobe are all 0.
- R2: While not busy, load_en equals the load strobe. Each cycle with load_en high advances the position counter by one, wrapping from 15 to 0.
- R3: A start pulse while idle makes busy 1 on the next cycle, with position 0 and round 0.
- R4: Busy stays high for exactly 160 consecutive cycles (10 rounds of 16 bytes), and shift_en is high on every one of them. Busy then reads 0 with both counters at 0.
- R5: While busy, the position steps 0..15 once per cycle. The round index increments by one each time the position wraps from 15 to 0.
- R6: The column-start strobe is high exactly when busy, the position is 0, 4, 8 or 12, and the round is 0 to 8. mix_en is high exactly when busy and the round is 0 to 8, so round 9 has no column mixing.
- R7: mix_take pulses for one cycle on the cycle after position 3, 7, 11 or 15 of rounds 0 to 8, and at no other time.
- R8: While busy, ks_step carries a code set by the position: 1 (substitute with round constant) at position 0, 2 (substitute) at positions 1 and 2, 3 (substitute from the rotation hold register) at position 3, 0 (chain XOR) at positions 4 to 11, and 4 (pass-through) at positions 12 to 15. ks_seq always equals the position.
- R9: rcon_o gives the round constant for the round index: 01, 02, 04, 08, 10, 20, 40, 80, 1B, 36 for rounds 0 to 9.
- R10: While not busy, shift_en and out_valid both equal the unload strobe. Each unload cycle advances the position by one.
- R11: With load and unload both high while idle, load_en, shift_en and out_valid are all 1, and the position advances by exactly one per cycle.
- R12: While idle with no strobe raised, both enables are 0 and the position holds.
- R13: While busy, load, unload and start strobes are ignored. load_en and out_valid stay 0, and the position and round sequence carries on unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| load_i | input | 1 | Host strobe: a state/key byte pair is present this cycle |
| start_i | input | 1 | Host pulse: begin encryption |
| unload_i | input | 1 | Host strobe: take one result byte this cycle |
| busy_o | output | 1 | Rounds in progress |
| pos_o | output | 4 | Byte-position counter |
| round_o | output | 4 | Round index |
| ks_seq_o | output | 4 | Key-schedule step index (equals position) |
| ks_step_o | output | 3 | Key-schedule step code (see R8) |
| rcon_o | output | 8 | Round constant for the current round |
| col_start_o | output | 1 | Column-mixer restart on the first byte of a column |
| mix_en_o | output | 1 | Select the column-mixer result path |
| mix_take_o | output | 1 | Column-mixer four outputs are complete |
| load_en_o | output | 1 | Shift the host byte into state and key registers |
| shift_en_o | output | 1 | Advance the state and key registers |
| out_valid_o | output | 1 | Result byte valid on the datapath output |

## Verification
The hardest condition to reach from the ports is the last round. Only there does column mixing switch off while byte stepping goes on, and getting there takes 144 cycles of correct sequencing first. The bench runs full encryptions and tracks the expected position and round on every busy cycle. It checks the column-start strobe, mix_take, the step code and the round constant against the round-9 rule at every step. In one run it also raises all three host strobes in the middle of a round, to show they leave the sequence untouched.

// File: rtl/aes_bs_pkg.sv
package aes_bs_pkg;

  localparam int RNDW = 4;

  typedef enum logic [2:0] {
    KS_CHAIN    = 3'd0,
    KS_SUB_RCON = 3'd1,
    KS_SUB      = 3'd2,
    KS_SUB_ROT  = 3'd3,
    KS_PASS     = 3'd4
  } ks_step_e;

  // multiply by x in GF(2^8), modulus x^8+x^4+x^3+x+1
  function automatic logic [7:0] gf_xtime(input logic [7:0] a);
    return {a[6:0], 1'b0} ^ (a[7] ? 8'h1B : 8'h00);
  endfunction

  // round constant: x^r in GF(2^8)
  function automatic logic [7:0] rcon_of(input logic [RNDW-1:0] r);
    logic [7:0] v;
    v = 8'h01;
    for (int i = 0; i < (1 << RNDW) - 1; i++) begin
      if (i < int'(r)) v = gf_xtime(v);
    end
    return v;
  endfunction

endpackage

// File: rtl/aes_bs_seq.sv
module aes_bs_seq
  import aes_bs_pkg::*;
#(
  parameter int NBYTES  = 16,
  parameter int NROUNDS = 10,
  parameter int POSW    = $clog2(NBYTES)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            go,
  input  logic            adv,
  output logic [POSW-1:0] pos,
  output logic [RNDW-1:0] round,
  output logic            busy
);

  localparam logic [POSW-1:0] P_LAST = POSW'(NBYTES - 1);
  localparam logic [RNDW-1:0] R_LAST = RNDW'(NROUNDS - 1);

  logic wrap;
  assign wrap = (pos == P_LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      pos   <= '0;
      round <= '0;
      busy  <= 1'b0;
    end else if (go) begin
      pos   <= '0;
      round <= '0;
      busy  <= 1'b1;
    end else begin
      if (adv) pos <= wrap ? '0 : pos + POSW'(1);
      if (busy && wrap) begin
        if (round == R_LAST) begin
          busy  <= 1'b0;
          round <= '0;
        end else begin
          round <= round + RNDW'(1);
        end
      end
    end
  end

endmodule

// File: rtl/aes_bs_decode.sv
module aes_bs_decode
  import aes_bs_pkg::*;
#(
  parameter int NBYTES  = 16,
  parameter int NROUNDS = 10,
  parameter int COLW    = 4,
  parameter int POSW    = $clog2(NBYTES)
) (
  input  logic [POSW-1:0] pos,
  input  logic [RNDW-1:0] round,
  input  logic            busy,
  input  logic            load,
  input  logic            unload,
  output logic            col_start,
  output logic            col_end,
  output logic            mix_en,
  output ks_step_e        ks_step,
  output logic [7:0]      rcon,
  output logic            load_en,
  output logic            shift_en,
  output logic            out_valid
);

  localparam int CW = $clog2(COLW);
  localparam logic [RNDW-1:0] R_LAST = RNDW'(NROUNDS - 1);
  localparam logic [POSW-1:0] P_ROT  = POSW'(COLW - 1);
  localparam logic [POSW-1:0] P_PASS = POSW'(NBYTES - COLW);

  logic [CW-1:0] in_col;
  assign in_col = pos[CW-1:0];

  always_comb begin
    mix_en    = busy && (round != R_LAST);
    col_start = mix_en && (in_col == '0);
    col_end   = mix_en && (in_col == CW'(COLW - 1));
    load_en   = load && !busy;
    out_valid = unload && !busy;
    shift_en  = busy || out_valid;
    rcon      = rcon_of(round);
    if (pos == '0)          ks_step = KS_SUB_RCON;
    else if (pos < P_ROT)   ks_step = KS_SUB;
    else if (pos == P_ROT)  ks_step = KS_SUB_ROT;
    else if (pos >= P_PASS) ks_step = KS_PASS;
    else                    ks_step = KS_CHAIN;
  end

endmodule

// File: rtl/aes_bs_ctrl.sv
module aes_bs_ctrl
  import aes_bs_pkg::*;
#(
  parameter int NBYTES  = 16,
  parameter int NROUNDS = 10,
  parameter int COLW    = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       load_i,
  input  logic       start_i,
  input  logic       unload_i,
  output logic       busy_o,
  output logic [3:0] pos_o,
  output logic [3:0] round_o,
  output logic [3:0] ks_seq_o,
  output logic [2:0] ks_step_o,
  output logic [7:0] rcon_o,
  output logic       col_start_o,
  output logic       mix_en_o,
  output logic       mix_take_o,
  output logic       load_en_o,
  output logic       shift_en_o,
  output logic       out_valid_o
);

  localparam int POSW = $clog2(NBYTES);

  logic [POSW-1:0] pos;
  logic [RNDW-1:0] round;
  logic            busy, go, col_end, load_en, shift_en;
  ks_step_e        ks_step;

  assign go = start_i && !busy;

  aes_bs_seq #(.NBYTES(NBYTES), .NROUNDS(NROUNDS), .POSW(POSW)) u_seq (
    .clk(clk), .rst(rst), .go(go), .adv(load_en || shift_en),
    .pos(pos), .round(round), .busy(busy)
  );

  aes_bs_decode #(.NBYTES(NBYTES), .NROUNDS(NROUNDS), .COLW(COLW), .POSW(POSW)) u_dec (
    .pos(pos), .round(round), .busy(busy), .load(load_i), .unload(unload_i),
    .col_start(col_start_o), .col_end(col_end), .mix_en(mix_en_o),
    .ks_step(ks_step), .rcon(rcon_o), .load_en(load_en),
    .shift_en(shift_en), .out_valid(out_valid_o)
  );

  always_ff @(posedge clk) begin
    if (rst) mix_take_o <= 1'b0;
    else     mix_take_o <= col_end;
  end

  assign busy_o     = busy;
  assign pos_o      = 4'(pos);
  assign ks_seq_o   = 4'(pos);
  assign round_o    = 4'(round);
  assign ks_step_o  = 3'(ks_step);
  assign load_en_o  = load_en;
  assign shift_en_o = shift_en;

endmodule

// File: rtl/aes_bs_ctrl_chk.sv
module aes_bs_ctrl_chk #(
  parameter int NROUNDS = 10
) (
  input logic       clk,
  input logic       rst,
  input logic       load_i,
  input logic       start_i,
  input logic       unload_i,
  input logic       busy_o,
  input logic [3:0] pos_o,
  input logic [3:0] round_o,
  input logic       col_start_o,
  input logic       load_en_o,
  input logic       shift_en_o
);

  localparam logic [3:0] R_LAST = 4'(NROUNDS - 1);

  // R3: start while idle begins a fresh pass
  a_r3_start_clears: assert property (@(posedge clk) disable iff (rst)
    (start_i && !busy_o) |=> (busy_o && pos_o == 4'd0 && round_o == 4'd0));

  // R4: registers advance on every busy cycle
  a_r4_shift_when_busy: assert property (@(posedge clk) disable iff (rst)
    busy_o |-> shift_en_o);

  // R5: round steps on position wrap
  a_r5_round_step: assert property (@(posedge clk) disable iff (rst)
    (busy_o && pos_o == 4'd15 && round_o != R_LAST) |=> (round_o == $past(round_o) + 4'd1));

  // R6: no column start in the last round or outside a column boundary
  a_r6_col_start_legal: assert property (@(posedge clk) disable iff (rst)
    col_start_o |-> (busy_o && pos_o[1:0] == 2'd0 && round_o != R_LAST));

  // R12: idle with no strobes stalls the position
  a_r12_idle_stall: assert property (@(posedge clk) disable iff (rst)
    (!busy_o && !load_i && !unload_i && !start_i) |=> $stable(pos_o));

  // R13: loading is blocked while busy
  a_r13_no_load_busy: assert property (@(posedge clk) disable iff (rst)
    busy_o |-> !load_en_o);

endmodule

bind aes_bs_ctrl aes_bs_ctrl_chk #(.NROUNDS(NROUNDS)) u_chk (
  .clk(clk), .rst(rst), .load_i(load_i), .start_i(start_i), .unload_i(unload_i),
  .busy_o(busy_o), .pos_o(pos_o), .round_o(round_o), .col_start_o(col_start_o),
  .load_en_o(load_en_o), .shift_en_o(shift_en_o)
);

// File: tb/aes_bs_ctrl_tb.sv
module aes_bs_ctrl_tb;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic load = 1'b0, start = 1'b0, unload = 1'b0;
  logic busy, col_start, mix_en, mix_take, load_en, shift_en, out_valid;
  logic [3:0] pos, round, ks_seq;
  logic [2:0] ks_step;
  logic [7:0] rcon;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  aes_bs_ctrl u_dut (
    .clk(clk), .rst(rst), .load_i(load), .start_i(start), .unload_i(unload),
    .busy_o(busy), .pos_o(pos), .round_o(round), .ks_seq_o(ks_seq),
    .ks_step_o(ks_step), .rcon_o(rcon), .col_start_o(col_start),
    .mix_en_o(mix_en), .mix_take_o(mix_take), .load_en_o(load_en),
    .shift_en_o(shift_en), .out_valid_o(out_valid)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // inputs change at posedge+1, checks happen at posedge+2
  task automatic cyc();
    @(posedge clk);
    #1;
  endtask

  function automatic int exp_step(input int p);
    if (p == 0) return 1;
    if (p < 3) return 2;
    if (p == 3) return 3;
    if (p >= 12) return 4;
    return 0;
  endfunction

  function automatic int exp_rcon(input int r);
    case (r)
      0: return 8'h01; 1: return 8'h02; 2: return 8'h04; 3: return 8'h08;
      4: return 8'h10; 5: return 8'h20; 6: return 8'h40; 7: return 8'h80;
      8: return 8'h1B; default: return 8'h36;
    endcase
  endfunction

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) cyc();
    rst = 1'b0;
    #1;
    chk("R1 busy", busy, 0);
    chk("R1 pos", pos, 0);
    chk("R1 round", round, 0);
    chk("R1 load_en", load_en, 0);
    chk("R1 shift_en", shift_en, 0);
    chk("R1 col_start", col_start, 0);
  endtask

  task automatic t_load();
    for (int k = 0; k < 16; k++) begin
      load = 1'b1;
      #1;
      chk("R2 load_en", load_en, 1);
      chk("R2 pos", pos, k);
      chk("R10 out_valid off", out_valid, 0);
      cyc();
    end
    load = 1'b0;
    #1;
    chk("R2 pos wrapped", pos, 0);
  endtask

  task automatic t_idle();
    int p0;
    p0 = pos;
    for (int k = 0; k < 5; k++) begin
      #1;
      chk("R12 load_en", load_en, 0);
      chk("R12 shift_en", shift_en, 0);
      chk("R12 pos hold", pos, p0);
      cyc();
    end
  endtask

  task automatic t_run(input bit disturb);
    int busy_n;
    bit prev_end;
    start = 1'b1;
    #1;
    chk("R3 idle before", busy, 0);
    cyc();
    start = 1'b0;
    #1;
    chk("R3 busy", busy, 1);
    chk("R3 pos", pos, 0);
    chk("R3 round", round, 0);
    busy_n = 0;
    prev_end = 1'b0;
    for (int c = 0; c < 160; c++) begin
      int p, r;
      p = c % 16;
      r = c / 16;
      if (disturb && c == 37) begin
        load = 1'b1; unload = 1'b1; start = 1'b1;
      end
      #1;
      if (busy) busy_n++;
      chk("R4 shift_en", shift_en, 1);
      chk("R5 pos", pos, p);
      chk("R5 round", round, r);
      chk("R6 col_start", col_start, (p % 4 == 0 && r != 9) ? 1 : 0);
      chk("R6 mix_en", mix_en, (r != 9) ? 1 : 0);
      chk("R7 mix_take", mix_take, prev_end ? 1 : 0);
      chk("R8 ks_step", ks_step, exp_step(p));
      chk("R8 ks_seq", ks_seq, p);
      chk("R9 rcon", rcon, exp_rcon(r));
      if (disturb && c == 37) begin
        chk("R13 load_en", load_en, 0);
        chk("R13 out_valid", out_valid, 0);
      end
      prev_end = (p % 4 == 3) && (r != 9);
      cyc();
      load = 1'b0; unload = 1'b0; start = 1'b0;
    end
    #1;
    chk("R4 busy count", busy_n, 160);
    chk("R4 busy low", busy, 0);
    chk("R4 pos", pos, 0);
    chk("R4 round", round, 0);
    chk("R7 no take after round 9", mix_take, 0);
  endtask

  task automatic t_unload();
    for (int k = 0; k < 16; k++) begin
      unload = 1'b1;
      #1;
      chk("R10 out_valid", out_valid, 1);
      chk("R10 shift_en", shift_en, 1);
      chk("R10 load_en off", load_en, 0);
      chk("R10 pos", pos, k);
      cyc();
    end
    unload = 1'b0;
  endtask

  task automatic t_overlap();
    for (int k = 0; k < 16; k++) begin
      load = 1'b1;
      unload = 1'b1;
      #1;
      chk("R11 load_en", load_en, 1);
      chk("R11 shift_en", shift_en, 1);
      chk("R11 out_valid", out_valid, 1);
      chk("R11 pos", pos, k);
      cyc();
    end
    load = 1'b0;
    unload = 1'b0;
    #1;
    chk("R11 pos wrapped", pos, 0);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(8 * 150000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    cyc();
    t_reset();
    t_load();
    t_idle();
    t_run(1'b0);
    t_idle();
    t_unload();
    t_overlap();
    t_run(1'b1);
    t_unload();
    t_idle();
    summary();
  end

endmodule